// File: doc/BRIEF.md
# Fuse-Driven PLL Calibration Sequencer

This block runs once after reset to load factory calibration codes into the PLL banks of a serial-link block. It samples a 32-bit fuse word and uses a two-bit select field in that word to decide whether calibration is needed at all. When calibration is needed, it walks the banks one after another. For each bank it reads the configured rate code and, from that code, picks one of two code sets packed in the fuse word. Each set holds a band code (BC, 1 bit), a bias code (DC, 3 bits) and a fine code (FC, 6 bits).

The codes are merged into the bank's control registers by read-modify-write accesses. The block then enables the calibration override and bypass bits. It reads a status register back to confirm each code; the bias readback is opened only for a short window around a single read. It then waits a settle time derived from the clock frequency and samples the bank's lock indicator.

Results appear as sticky per-bank error flags and a one-cycle done pulse. The register file is reached through a simple synchronous port. That port carries one access at a time, and read data returns one cycle after the request.

Top module: `pll_fuse_cal_seq`

## Requirements
- R1: The select field is fuse bits [31:30] and is sampled in the first cycle after reset. If it is neither 1 nor 2, no register access is made and done pulses after exactly one clock edge.
- R2: The rate code is control-0 bits [19:16]. Codes 0xA, 0xC and 0x5 take set 1 from the fuse word (BC bit 29, DC [28:26], FC [25:20]). Code 0x9 takes set 2 (BC bit 19, DC [18:16], FC [15:10]). Any other code leaves that bank's registers unchanged and costs two cycles.
- R3: For a calibrated bank, control-1 ends as its prior value ORed with BC at bit 29, FC at [20:15], and bits 28 and 25.
- R4: For a calibrated bank, control-0 ends as its prior value ORed with DC at [7:5], with bit 25 clear.
- R5: Status-2 bit 23 is compared with BC and status-2 [21:16] with FC. A difference sets the bank's sticky bc_err or fc_err bit.
- R6: Status-2 [19:17] is compared with DC in exactly one status read made while control-0 bit 25 is set. A difference sets the bank's sticky dc_err bit.
- R7: After the checks the block waits SETTLE_US*CLK_HZ/1e6 cycles and then reads control-0. If bit 23 of that read is 0, the bank's sticky lock_fail bit is set.
- R8: Register port encoding: reg_sel 0 is control-0, 1 is control-1 and 2 is status-2. A write is issued only in the cycle right after a read of the same register and bank, and its data is formed from that read's data.
- R9: done is high for one cycle. It comes 1 + sum of per-bank costs edges after reset release, where a calibrated bank costs 18 + wait cycles and a skipped bank costs 2. No register access follows done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fuse_word | input | 32 | Factory fuse word |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_bank | output | BW | Bank index |
| reg_sel | output | 2 | 0 control-0, 1 control-1, 2 status-2 |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid one cycle after a read request |
| done | output | 1 | One-cycle completion pulse |
| bc_err | output | NUM_BANKS | Sticky BC mismatch per bank |
| fc_err | output | NUM_BANKS | Sticky FC mismatch per bank |
| dc_err | output | NUM_BANKS | Sticky DC mismatch per bank |
| lock_fail | output | NUM_BANKS | Sticky lock failure per bank |

## Verification
The done pulse is expected a known number of edges after reset release. That count is one edge for a rejected select field, plus 2 for each skipped bank and 18 plus the settle count for each calibrated bank. The bench counts edges from the release and compares that count with the figure it computes. Register contents, readback-window counts and sticky flags are read only after done, once every access has landed in the bench's register model. One cycle after done the bench checks that done has fallen, and a few cycles later it checks that no further access has occurred.

// File: rtl/pll_fuse_cal_seq.sv
module pll_fuse_cal_seq #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned SETTLE_US = 750,
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          fuse_word,
  output logic                 reg_req,
  output logic                 reg_we,
  output logic [BW-1:0]        reg_bank,
  output logic [1:0]           reg_sel,
  output logic [31:0]          reg_wdata,
  input  logic [31:0]          reg_rdata,
  output logic                 done,
  output logic [NUM_BANKS-1:0] bc_err,
  output logic [NUM_BANKS-1:0] fc_err,
  output logic [NUM_BANKS-1:0] dc_err,
  output logic [NUM_BANKS-1:0] lock_fail
);
  localparam int unsigned WAIT_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;
  localparam int CW = $clog2(WAIT_CYC + 1);
  localparam logic [1:0] SEL_C0 = 2'd0, SEL_C1 = 2'd1, SEL_S2 = 2'd2;
  localparam logic [31:0] OVR_BYP = 32'h1200_0000;
  localparam logic [31:0] DC_RDEN = 32'h0200_0000;

  typedef enum logic [4:0] {
    ST_START, ST_RATE_RD, ST_RATE_EV,
    ST_C1A_RD, ST_C1A_WR, ST_C0A_RD, ST_C0A_WR, ST_C1B_RD, ST_C1B_WR,
    ST_S2A_RD, ST_S2A_EV, ST_C0B_RD, ST_C0B_WR, ST_S2B_RD, ST_S2B_EV,
    ST_C0C_RD, ST_C0C_WR, ST_WAIT, ST_LK_RD, ST_LK_EV, ST_DONE, ST_IDLE
  } st_t;

  st_t           st;
  logic [BW-1:0] bank;
  logic [31:0]   fz;
  logic          bc_q;
  logic [2:0]    dc_q;
  logic [5:0]    fc_q;
  logic [CW-1:0] cnt;

  wire [1:0] fsel   = fuse_word[31:30];
  wire       sel_ok = (fsel == 2'd1) || (fsel == 2'd2);
  wire [3:0] rate   = reg_rdata[19:16];
  wire       use1   = (rate == 4'hA) || (rate == 4'hC) || (rate == 4'h5);
  wire       use2   = (rate == 4'h9);
  wire       last   = (bank == BW'(NUM_BANKS - 1));

  assign reg_bank = bank;
  assign done     = (st == ST_DONE);

  always_comb begin
    reg_req   = 1'b0;
    reg_we    = 1'b0;
    reg_sel   = SEL_C0;
    reg_wdata = '0;
    case (st)
      ST_RATE_RD, ST_C0A_RD, ST_C0B_RD, ST_C0C_RD, ST_LK_RD: reg_req = 1'b1;
      ST_C1A_RD, ST_C1B_RD: begin reg_req = 1'b1; reg_sel = SEL_C1; end
      ST_S2A_RD, ST_S2B_RD: begin reg_req = 1'b1; reg_sel = SEL_S2; end
      ST_C1A_WR: begin
        reg_req = 1'b1; reg_we = 1'b1; reg_sel = SEL_C1;
        reg_wdata = reg_rdata | (32'(bc_q) << 29) | (32'(fc_q) << 15);
      end
      ST_C0A_WR: begin
        reg_req = 1'b1; reg_we = 1'b1;
        reg_wdata = reg_rdata | (32'(dc_q) << 5);
      end
      ST_C1B_WR: begin
        reg_req = 1'b1; reg_we = 1'b1; reg_sel = SEL_C1;
        reg_wdata = reg_rdata | OVR_BYP;
      end
      ST_C0B_WR: begin
        reg_req = 1'b1; reg_we = 1'b1;
        reg_wdata = reg_rdata | DC_RDEN;
      end
      ST_C0C_WR: begin
        reg_req = 1'b1; reg_we = 1'b1;
        reg_wdata = reg_rdata & ~DC_RDEN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_START;
      bank      <= '0;
      fz        <= '0;
      bc_q      <= 1'b0;
      dc_q      <= '0;
      fc_q      <= '0;
      cnt       <= '0;
      bc_err    <= '0;
      fc_err    <= '0;
      dc_err    <= '0;
      lock_fail <= '0;
    end else begin
      case (st)
        ST_START: begin
          fz <= fuse_word;
          st <= sel_ok ? ST_RATE_RD : ST_DONE;
        end
        ST_RATE_EV: begin
          if (use1) begin
            bc_q <= fz[29]; dc_q <= fz[28:26]; fc_q <= fz[25:20];
            st <= ST_C1A_RD;
          end else if (use2) begin
            bc_q <= fz[19]; dc_q <= fz[18:16]; fc_q <= fz[15:10];
            st <= ST_C1A_RD;
          end else if (last) begin
            st <= ST_DONE;
          end else begin
            bank <= bank + 1'b1;
            st   <= ST_RATE_RD;
          end
        end
        ST_S2A_EV: begin
          if (reg_rdata[23] != bc_q)    bc_err[bank] <= 1'b1;
          if (reg_rdata[21:16] != fc_q) fc_err[bank] <= 1'b1;
          st <= ST_C0B_RD;
        end
        ST_S2B_EV: begin
          if (reg_rdata[19:17] != dc_q) dc_err[bank] <= 1'b1;
          st <= ST_C0C_RD;
        end
        ST_C0C_WR: begin
          cnt <= CW'(WAIT_CYC - 1);
          st  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (cnt == '0) st <= ST_LK_RD;
          else           cnt <= cnt - 1'b1;
        end
        ST_LK_EV: begin
          if (!reg_rdata[23]) lock_fail[bank] <= 1'b1;
          if (last) st <= ST_DONE;
          else begin
            bank <= bank + 1'b1;
            st   <= ST_RATE_RD;
          end
        end
        ST_DONE: st <= ST_IDLE;
        ST_IDLE: st <= ST_IDLE;
        default: st <= st_t'(st + 5'd1);
      endcase
    end
  end

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_START && !sel_ok) |=> (done && !reg_req)); // R1
  AST_RMW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we) |-> ($past(reg_req && !reg_we) && $past(reg_sel) == reg_sel
                             && $past(reg_bank) == reg_bank)); // R8
  AST_NO_STATUS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we) |-> (reg_sel != SEL_S2)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !reg_req)); // R9
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((bc_err | fc_err | dc_err | lock_fail) &
              $past(bc_err | fc_err | dc_err | lock_fail)) ==
              $past(bc_err | fc_err | dc_err | lock_fail))); // R5
  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> (int'(reg_bank) < NUM_BANKS)); // R2
endmodule

// File: tb/tb_pll_fuse_cal_seq.sv
module tb_pll_fuse_cal_seq;
  localparam int NB = 4;
  localparam int CLK = 4_000_000;
  localparam int SETTLE = 750;
  localparam int W = (CLK / 1_000_000) * SETTLE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] fuse_word = '0;
  logic reg_req, reg_we;
  logic [1:0] reg_bank;
  logic [1:0] reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata = '0;
  logic done;
  logic [NB-1:0] bc_err, fc_err, dc_err, lock_fail;

  pll_fuse_cal_seq #(.NUM_BANKS(NB), .CLK_HZ(CLK), .SETTLE_US(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .fuse_word(fuse_word),
    .reg_req(reg_req), .reg_we(reg_we), .reg_bank(reg_bank), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(done),
    .bc_err(bc_err), .fc_err(fc_err), .dc_err(dc_err), .lock_fail(lock_fail));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] init0 [NB];
  logic [31:0] init1 [NB];
  logic        bcf   [NB];
  logic [5:0]  fcf   [NB];
  logic [2:0]  dcf   [NB];
  logic        nolock[NB];
  logic [31:0] m_cr0 [NB];
  logic [31:0] m_cr1 [NB];
  int          dcwin [NB];
  int          acc;

  function automatic logic [31:0] rd_val(input int b, input logic [1:0] s);
    logic [31:0] v;
    v = '0;
    if (s == 2'd0) begin
      v = m_cr0[b];
      v[23] = m_cr1[b][28] & m_cr1[b][25] & ~nolock[b];
    end else if (s == 2'd1) begin
      v = m_cr1[b];
    end else begin
      v[23] = m_cr1[b][29] ^ bcf[b];
      v[21:16] = m_cr1[b][20:15] ^ fcf[b];
      if (m_cr0[b][25]) v[19:17] = m_cr0[b][7:5] ^ dcf[b];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (reg_req) begin
      acc <= acc + 1;
      if (reg_we) begin
        if (reg_sel == 2'd0) m_cr0[reg_bank] <= reg_wdata & ~32'h0080_0000;
        else if (reg_sel == 2'd1) m_cr1[reg_bank] <= reg_wdata;
      end else begin
        reg_rdata <= rd_val(int'(reg_bank), reg_sel);
        if (reg_sel == 2'd2 && m_cr0[reg_bank][25]) dcwin[reg_bank] <= dcwin[reg_bank] + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL R9 watchdog: act=%0d exp<190000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!c) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkfuse(input logic [1:0] s, input logic b1, input logic [2:0] d1,
      input logic [5:0] f1, input logic b2, input logic [2:0] d2, input logic [5:0] f2);
    return {s, b1, d1, f1, b2, d2, f2, 10'h155};
  endfunction

  task automatic clear_cfg();
    for (int b = 0; b < NB; b++) begin
      bcf[b] = 1'b0; fcf[b] = '0; dcf[b] = '0; nolock[b] = 1'b0;
      init1[b] = 32'h0000_0042 + 32'(b);
    end
  endtask

  task automatic set_rate(input int b, input logic [3:0] r);
    init0[b] = {12'h000, r, 16'h0008} | (32'(b) << 10);
  endtask

  task automatic run_and_check(input logic [31:0] fz, input string name);
    int edges, exp_edges, acc_done;
    logic ok, proc, bc;
    logic [2:0] dc;
    logic [5:0] fc;
    logic [3:0] r;
    logic [31:0] e0, e1;
    rst_n = 1'b0;
    fuse_word = fz;
    acc = 0;
    for (int b = 0; b < NB; b++) begin
      m_cr0[b] = init0[b]; m_cr1[b] = init1[b]; dcwin[b] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    edges = 0;
    while (!done && edges < 20000) begin
      @(posedge clk); edges++; @(negedge clk);
    end
    ok = (fz[31:30] == 2'd1) || (fz[31:30] == 2'd2);
    exp_edges = 1;
    if (ok)
      for (int b = 0; b < NB; b++) begin
        r = init0[b][19:16];
        exp_edges += (r == 4'hA || r == 4'hC || r == 4'h5 || r == 4'h9) ? 18 + W : 2;
      end
    chk(edges == exp_edges, {"R9 done timing ", name}, edges, exp_edges);
    acc_done = acc;
    @(posedge clk); @(negedge clk);
    chk(!done, {"R9 done pulse width ", name}, done, 0);
    repeat (4) @(negedge clk);
    chk(acc == acc_done, {"R9 no access after done ", name}, acc, acc_done);
    if (!ok) chk(acc == 0, {"R1 gated off, no access ", name}, acc, 0);
    for (int b = 0; b < NB; b++) begin
      r = init0[b][19:16];
      proc = ok && (r == 4'hA || r == 4'hC || r == 4'h5 || r == 4'h9);
      if (r == 4'h9) begin bc = fz[19]; dc = fz[18:16]; fc = fz[15:10]; end
      else begin bc = fz[29]; dc = fz[28:26]; fc = fz[25:20]; end
      e1 = proc ? (init1[b] | (32'(bc) << 29) | (32'(fc) << 15) | 32'h1200_0000) : init1[b];
      e0 = proc ? ((init0[b] | (32'(dc) << 5)) & ~32'h0200_0000) : init0[b];
      chk(m_cr1[b] == e1, {"R3/R2 control-1 ", name}, m_cr1[b], e1);
      chk(m_cr0[b] == e0, {"R4/R2 control-0 ", name}, m_cr0[b], e0);
      chk(dcwin[b] == (proc ? 1 : 0), {"R6 readback window ", name}, dcwin[b], proc ? 1 : 0);
      chk(bc_err[b] == (proc && bcf[b]), {"R5 bc_err ", name}, bc_err[b], proc && bcf[b]);
      chk(fc_err[b] == (proc && fcf[b] != 0), {"R5 fc_err ", name}, fc_err[b], proc && fcf[b] != 0);
      chk(dc_err[b] == (proc && dcf[b] != 0), {"R6 dc_err ", name}, dc_err[b], proc && dcf[b] != 0);
      chk(lock_fail[b] == (proc && nolock[b]), {"R7 lock_fail ", name}, lock_fail[b], proc && nolock[b]);
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    #1;
    chk(!done && !reg_req, "R9 reset: done/req low", {done, reg_req}, 0);
    chk((bc_err | fc_err | dc_err | lock_fail) == 0, "R5 reset: flags clear",
        bc_err | fc_err | dc_err | lock_fail, 0);
  endtask

  task automatic t_gate_off();
    clear_cfg();
    for (int b = 0; b < NB; b++) set_rate(b, 4'hA);
    run_and_check(mkfuse(2'd0, 1, 3'd5, 6'h2B, 1, 3'd3, 6'h35), "R1 sel0");
    run_and_check(mkfuse(2'd3, 1, 3'd5, 6'h2B, 1, 3'd3, 6'h35), "R1 sel3");
  endtask

  task automatic t_all_rates();
    clear_cfg();
    set_rate(0, 4'hA); set_rate(1, 4'hC); set_rate(2, 4'h5); set_rate(3, 4'h9);
    run_and_check(mkfuse(2'd1, 1, 3'd5, 6'h2B, 0, 3'd3, 6'h35), "R2 rates sel1");
  endtask

  task automatic t_skip_codes();
    clear_cfg();
    set_rate(0, 4'h0); set_rate(1, 4'h9); set_rate(2, 4'hF); set_rate(3, 4'h3);
    run_and_check(mkfuse(2'd2, 0, 3'd6, 6'h11, 1, 3'd2, 6'h3C), "R2 skip sel2");
  endtask

  task automatic t_faults();
    clear_cfg();
    set_rate(0, 4'h9); set_rate(1, 4'hA); set_rate(2, 4'h5); set_rate(3, 4'hC);
    bcf[0] = 1'b1; fcf[1] = 6'h04; dcf[2] = 3'h2; nolock[3] = 1'b1;
    run_and_check(mkfuse(2'd1, 0, 3'd7, 6'h3F, 1, 3'd1, 6'h01), "R5/R6/R7 faults");
  endtask

  initial begin
    clear_cfg();
    for (int b = 0; b < NB; b++) begin
      set_rate(b, 4'h0); m_cr0[b] = '0; m_cr1[b] = '0; dcwin[b] = 0;
    end
    acc = 0;
    t_reset_state();
    t_gate_off();
    t_all_rates();
    t_skip_codes();
    t_faults();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule